// File: doc/BRIEF.md
# Nibble-Loaded Interrupt Timer with Program Bank Select

This block is a cartridge-side interrupt timer that shares a write-only address window with one program bank register. The CPU builds a 16-bit reload value four bits at a time, writing to four separate address regions. It then arms the timer through a control register. While the timer is armed, the counter advances once per CPU clock enable. When it wraps, it reloads itself and raises an interrupt request. The request stays high until software acknowledges it.

The control register selects a full 16-bit count or a narrow 8-bit count. In narrow mode only the low byte of the counter is loaded and advanced, and the high byte keeps whatever value it had. The control register also holds a stored enable value. The acknowledge register copies that value back into the run enable, so software can acknowledge and re-arm with a single write. A separate register picks the 16 KB program bank shown in the lower program window. The upper program window is tied to the last bank.

Top module: `irq_bank_timer`

## Requirements
- R1: After a synchronous reset the IRQ output is 0, the lower bank output is 0, and the reload value, counter, mode and both enable bits are 0. The upper bank output always equals NUM_BANKS-1.
- R2: A write whose address bits [15:12] are 0x8, 0x9, 0xA or 0xB loads write data bits [3:0] into reload bits [3:0], [7:4], [11:8] or [15:12] respectively. The other three nibbles are left unchanged.
- R3: A write to region 0xC stores data bit 2 as the mode (1 = 8-bit), data bit 1 as the run enable and data bit 0 as the stored re-arm value, and it clears the IRQ.
- R4: A region 0xC write with data bit 1 set loads the counter from the reload value: all 16 bits in 16-bit mode, only the low byte in 8-bit mode. With bit 1 clear the counter is not loaded. The counter does not advance in the cycle of a region 0xC write.
- R5: A region 0xD write clears the IRQ and copies the stored re-arm value into the run enable.
- R6: In 16-bit mode, while running and with the clock enable high, the counter increments by one. At 0xFFFF it instead reloads all 16 bits and sets the IRQ, which stays set until a region 0xC or 0xD write.
- R7: In 8-bit mode only the low byte increments. At 0xFF the low byte reloads from reload bits [7:0] and the IRQ is set, while counter bits [15:8] stay unchanged.
- R8: A region 0xF write sets the lower bank output to data bits [BANK_W-1:0]. Writes to region 0xE or to regions 0x0 to 0x7 change nothing.
- R9: If a wrap and a region 0xD acknowledge happen in the same cycle, the IRQ is set after that cycle.
- R10: While the run enable is 0 or the clock enable is low, the counter holds and no IRQ is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | ADDR_W | CPU write address |
| wr_data | input | DATA_W | CPU write data |
| cpu_ce | input | 1 | CPU clock enable, one count step when high |
| irq | output | 1 | Registered interrupt request, active high |
| prg_bank_lo | output | BANK_W | 16 KB bank for the lower program window |
| prg_bank_hi | output | BANK_W | 16 KB bank for the upper program window (last bank) |

## Verification
The risky coincidence is a counter wrap that lands in the same cycle as an acknowledge write. The wrap sets the request, the acknowledge clears it, and the acknowledge also rewrites the run enable that decides whether the counter steps at all. The bench loads a reload value one step below the wrap point, arms the timer, and issues the region 0xD write together with the clock enable on the wrapping cycle. It expects the request still high afterwards. Random traffic biased toward high reload nibbles hits the same case, and every cycle is judged against a bench model that counts with the pre-write enable and lets the set win over the clear.

// File: rtl/irqt_pkg.sv
package irqt_pkg;
  // Region codes taken from address bits [15:12]
  localparam logic [3:0] RGN_NIB0 = 4'h8;
  localparam logic [3:0] RGN_CTRL = 4'hC;
  localparam logic [3:0] RGN_ACK  = 4'hD;
  localparam logic [3:0] RGN_BANK = 4'hF;

  // Control word bit positions
  localparam int CTL_REARM = 0;
  localparam int CTL_RUN   = 1;
  localparam int CTL_MODE  = 2;

  typedef struct packed {
    logic mode8;
    logic run;
    logic rearm;
  } ctl_t;
endpackage

// File: rtl/irqt_decode.sv
module irqt_decode
  import irqt_pkg::*;
#(
  parameter int NIBBLES = 4
) (
  input  logic               wr_en,
  input  logic [3:0]         region,
  output logic [NIBBLES-1:0] nib_we,
  output logic               ctrl_we,
  output logic               ack_we,
  output logic               bank_we
);
  for (genvar g = 0; g < NIBBLES; g++) begin : g_nib
    assign nib_we[g] = wr_en && (region == 4'(RGN_NIB0 + g));
  end

  assign ctrl_we = wr_en && (region == RGN_CTRL);
  assign ack_we  = wr_en && (region == RGN_ACK);
  assign bank_we = wr_en && (region == RGN_BANK);
endmodule

// File: rtl/irqt_regs.sv
module irqt_regs
  import irqt_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CNT_W   = 16,
  parameter int NIB_W   = 4,
  parameter int BANK_W  = 6,
  localparam int NIBBLES = CNT_W / NIB_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NIBBLES-1:0] nib_we,
  input  logic               ctrl_we,
  input  logic               ack_we,
  input  logic               bank_we,
  input  logic [DATA_W-1:0]  wdata,
  output logic [CNT_W-1:0]   reload,
  output ctl_t               ctl,
  output logic               load_full,
  output logic               load_low,
  output logic [BANK_W-1:0]  bank
);
  for (genvar g = 0; g < NIBBLES; g++) begin : g_rel
    always_ff @(posedge clk) begin
      if (rst)            reload[g*NIB_W +: NIB_W] <= '0;
      else if (nib_we[g]) reload[g*NIB_W +: NIB_W] <= wdata[NIB_W-1:0];
    end

    p_nib_keep_r2: assert property (@(posedge clk) disable iff (rst)
      !nib_we[g] |=> $stable(reload[g*NIB_W +: NIB_W]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl <= '0;
    end else if (ctrl_we) begin
      ctl.mode8 <= wdata[CTL_MODE];
      ctl.run   <= wdata[CTL_RUN];
      ctl.rearm <= wdata[CTL_REARM];
    end else if (ack_we) begin
      ctl.run <= ctl.rearm;
    end
  end

  assign load_full = ctrl_we && wdata[CTL_RUN] && !wdata[CTL_MODE];
  assign load_low  = ctrl_we && wdata[CTL_RUN] &&  wdata[CTL_MODE];

  always_ff @(posedge clk) begin
    if (rst)          bank <= '0;
    else if (bank_we) bank <= wdata[BANK_W-1:0];
  end

  p_rearm_r5: assert property (@(posedge clk) disable iff (rst)
    ack_we && !ctrl_we |=> ctl.run == $past(ctl.rearm));
  p_bank_keep_r8: assert property (@(posedge clk) disable iff (rst)
    !bank_we |=> $stable(bank));
endmodule

// File: rtl/irqt_counter.sv
module irqt_counter #(
  parameter int CNT_W = 16,
  localparam int LOW_W = CNT_W / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             mode8,
  input  logic             load_full,
  input  logic             load_low,
  input  logic             hold,
  input  logic             clr,
  input  logic             cpu_ce,
  input  logic [CNT_W-1:0] reload,
  output logic             irq
);
  logic [CNT_W-1:0] cnt;
  logic tick, wrap_full, wrap_low, overflow;

  assign tick      = run && cpu_ce && !hold;
  assign wrap_full = (cnt == '1);
  assign wrap_low  = (cnt[LOW_W-1:0] == '1);
  assign overflow  = tick && (mode8 ? wrap_low : wrap_full);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      irq <= 1'b0;
    end else begin
      if (load_full) begin
        cnt <= reload;
      end else if (load_low) begin
        cnt[LOW_W-1:0] <= reload[LOW_W-1:0];
      end else if (tick) begin
        if (mode8)
          cnt[LOW_W-1:0] <= wrap_low ? reload[LOW_W-1:0] : cnt[LOW_W-1:0] + 1'b1;
        else
          cnt <= wrap_full ? reload : cnt + 1'b1;
      end
      if (overflow)  irq <= 1'b1;
      else if (clr)  irq <= 1'b0;
    end
  end

  p_wrap16_r6: assert property (@(posedge clk) disable iff (rst)
    tick && !mode8 && wrap_full |=> irq && cnt == $past(reload));
  p_keep_hi_r7: assert property (@(posedge clk) disable iff (rst)
    tick && mode8 |=> cnt[CNT_W-1:LOW_W] == $past(cnt[CNT_W-1:LOW_W]));
  p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    irq && !clr |=> irq);
  p_clear_r3: assert property (@(posedge clk) disable iff (rst)
    hold |=> !irq);
  p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
    clr && overflow |=> irq);
  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !tick && !load_full && !load_low |=> $stable(cnt));
endmodule

// File: rtl/irq_bank_timer.sv
module irq_bank_timer
  import irqt_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int CNT_W     = 16,
  parameter int NIB_W     = 4,
  parameter int NUM_BANKS = 64,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int NIBBLES  = CNT_W / NIB_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cpu_ce,
  output logic              irq,
  output logic [BANK_W-1:0] prg_bank_lo,
  output logic [BANK_W-1:0] prg_bank_hi
);
  localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(NUM_BANKS - 1);

  logic [3:0]         region;
  logic [NIBBLES-1:0] nib_we;
  logic               ctrl_we, ack_we, bank_we;
  logic [CNT_W-1:0]   reload;
  ctl_t               ctl;
  logic               load_full, load_low;
  logic               unused_addr;

  assign region      = wr_addr[ADDR_W-1 -: 4];
  assign unused_addr = ^wr_addr[ADDR_W-5:0];

  irqt_decode #(.NIBBLES(NIBBLES)) u_dec (
    .wr_en   (wr_en),
    .region  (region),
    .nib_we  (nib_we),
    .ctrl_we (ctrl_we),
    .ack_we  (ack_we),
    .bank_we (bank_we)
  );

  irqt_regs #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .NIB_W  (NIB_W),
    .BANK_W (BANK_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .nib_we    (nib_we),
    .ctrl_we   (ctrl_we),
    .ack_we    (ack_we),
    .bank_we   (bank_we),
    .wdata     (wr_data),
    .reload    (reload),
    .ctl       (ctl),
    .load_full (load_full),
    .load_low  (load_low),
    .bank      (prg_bank_lo)
  );

  irqt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .run       (ctl.run),
    .mode8     (ctl.mode8),
    .load_full (load_full),
    .load_low  (load_low),
    .hold      (ctrl_we),
    .clr       (ctrl_we || ack_we),
    .cpu_ce    (cpu_ce),
    .reload    (reload),
    .irq       (irq)
  );

  assign prg_bank_hi = LAST_BANK;

  p_hi_fixed_r1: assert property (@(posedge clk) prg_bank_hi == LAST_BANK);
endmodule

// File: tb/irq_bank_timer_test.sv
module irq_bank_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_BANKS  = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        cpu_ce = 1'b0;
  logic        irq;
  logic [5:0]  prg_bank_lo, prg_bank_hi;

  irq_bank_timer #(.NUM_BANKS(NUM_BANKS)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cpu_ce(cpu_ce), .irq(irq), .prg_bank_lo(prg_bank_lo), .prg_bank_hi(prg_bank_hi)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference state built from the requirements
  logic [15:0] m_reload, m_cnt;
  logic        m_run, m_rearm, m_mode8, m_irq;
  logic [5:0]  m_bank;
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic model_reset();
    m_reload = '0; m_cnt = '0; m_run = 0; m_rearm = 0; m_mode8 = 0; m_irq = 0; m_bank = '0;
  endtask

  task automatic model_step(input logic w, input logic [15:0] a, input logic [7:0] d, input logic ce);
    logic [3:0] r = a[15:12];
    bit tick = m_run && ce && !(w && r == 4'hC);
    bit set = 0;
    if (tick) begin
      if (m_mode8) begin
        if (m_cnt[7:0] == 8'hFF) begin m_cnt[7:0] = m_reload[7:0]; set = 1; end
        else m_cnt[7:0] = m_cnt[7:0] + 8'd1;
      end else begin
        if (m_cnt == 16'hFFFF) begin m_cnt = m_reload; set = 1; end
        else m_cnt = m_cnt + 16'd1;
      end
    end
    if (w) begin
      case (r)
        4'h8: m_reload[3:0]   = d[3:0];
        4'h9: m_reload[7:4]   = d[3:0];
        4'hA: m_reload[11:8]  = d[3:0];
        4'hB: m_reload[15:12] = d[3:0];
        4'hC: begin
          m_mode8 = d[2]; m_run = d[1]; m_rearm = d[0]; m_irq = 0;
          if (d[1]) begin
            if (d[2]) m_cnt[7:0] = m_reload[7:0];
            else      m_cnt = m_reload;
          end
        end
        4'hD: begin m_irq = 0; m_run = m_rearm; end
        4'hF: m_bank = d[5:0];
        default: ;
      endcase
    end
    if (set) m_irq = 1;
  endtask

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic w, input logic [15:0] a, input logic [7:0] d,
                      input logic ce, input string tag);
    @(negedge clk);
    wr_en = w; wr_addr = a; wr_data = d; cpu_ce = ce;
    @(posedge clk);
    model_step(w, a, d, ce);
    #1;
    check({tag, " irq"}, {15'd0, irq}, {15'd0, m_irq});
    check("R8 bank", {10'd0, prg_bank_lo}, {10'd0, m_bank});
  endtask

  task automatic set_reload(input logic [15:0] v, input string tag);
    for (int i = 0; i < 4; i++)
      step(1, 16'h8000 + 16'(i) * 16'h1000, {4'h0, v[i*4 +: 4]}, 0, tag);
  endtask

  task automatic run_ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 16'h0000, 8'h00, 1, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    check("R1 irq", {15'd0, irq}, 16'd0);
    check("R1 bank_lo", {10'd0, prg_bank_lo}, 16'd0);
    check("R1 bank_hi", {10'd0, prg_bank_hi}, 16'(NUM_BANKS - 1));
    run_ticks(5, "R1 R10 idle after reset");

    // R2 + R6: 16-bit wrap after 16 steps from 0xFFF0
    set_reload(16'hFFF0, "R2");
    step(1, 16'hC000, 8'h02, 1, "R3 R4 arm 16-bit");
    run_ticks(15, "R6 before wrap");
    check("R6 no irq yet", {15'd0, irq}, 16'd0);
    run_ticks(1, "R6 wrap");
    check("R6 irq on wrap", {15'd0, irq}, 16'd1);
    run_ticks(3, "R6 sticky");
    // only nibble 0 changes: reload becomes 0xFFFC
    step(1, 16'h8123, 8'hFC, 0, "R2 single nibble");
    step(1, 16'hC000, 8'h02, 1, "R3 clear and rearm");
    check("R3 clear", {15'd0, irq}, 16'd0);
    run_ticks(4, "R2 R6 wrap after 4");
    check("R2 R6 irq after 4", {15'd0, irq}, 16'd1);

    // R7: 8-bit mode keeps high byte
    step(1, 16'hC000, 8'h00, 0, "R3 stop");
    set_reload(16'hFF00, "R2");
    step(1, 16'hC000, 8'h02, 0, "R4 load full");
    set_reload(16'h00FD, "R2");
    step(1, 16'hC000, 8'h07, 0, "R4 load low, 8-bit, rearm");
    run_ticks(3, "R7 8-bit wrap");
    check("R7 irq 8-bit", {15'd0, irq}, 16'd1);
    step(1, 16'hC000, 8'h01, 0, "R3 16-bit, stopped, rearm");
    step(1, 16'hD000, 8'h00, 0, "R5 ack rearm");
    check("R5 ack clears", {15'd0, irq}, 16'd0);
    run_ticks(3, "R7 high byte kept");
    check("R7 high byte kept, 16-bit wrap", {15'd0, irq}, 16'd1);

    // R9: wrap and acknowledge in the same cycle
    set_reload(16'hFFFF, "R2");
    step(1, 16'hC000, 8'h03, 0, "R4 arm at FFFF");
    step(1, 16'hD000, 8'h00, 1, "R9 wrap with ack");
    check("R9 set wins", {15'd0, irq}, 16'd1);

    // R8/R10: ignored regions, bank select, disabled counter
    step(1, 16'hC000, 8'h00, 1, "R3 disable");
    step(1, 16'hE000, 8'hFF, 1, "R8 region E ignored");
    step(1, 16'h4000, 8'hFF, 1, "R8 low region ignored");
    step(1, 16'hF000, 8'hAB, 0, "R8 bank");
    check("R8 bank value", {10'd0, prg_bank_lo}, 16'h002B);
    run_ticks(300, "R10 disabled");
    check("R10 no irq", {15'd0, irq}, 16'd0);
    step(1, 16'hD000, 8'h00, 1, "R5 ack with rearm 0");
    run_ticks(20, "R10 still stopped");

    // Random traffic
    for (int i = 0; i < 20000; i++) begin
      logic w = ($urandom % 4) == 0;
      logic [15:0] a = {4'($urandom), 12'($urandom)};
      logic [7:0]  d = 8'($urandom);
      logic ce = ($urandom % 4) != 0;
      if (w && a[15:14] == 2'b10 && ($urandom % 2)) d[3:0] = 4'hF;
      if (w && a[15:12] == 4'hC && ($urandom % 4) != 0) d[1] = 1'b1;
      step(w, a, d, ce, "R6 R7 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule